// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a two-channel serial audio stream into parallel sample words. It runs entirely on the incoming bit clock. On every rising bit-clock edge it samples a frame clock, which tells the left channel from the right, and a serial data line. A 2-bit format select picks one of four framings. Two of them are MSB-aligned: the I2S-style format and the left-justified format. The other two are LSB-aligned: right-justified with 24-bit words and right-justified with 16-bit words.

Each time a stereo frame completes, the block presents the left and right words together as 24-bit values and raises a one-cycle valid strobe. Alongside them it gives a framing-error flag, which says whether that frame had fewer bit clocks than the selected format needs. Downstream logic in the same clock domain takes the words on the strobe. Clock generation, buffering and conversion sit outside this block.

Top module: `audio_serial_rx`

## Requirements
- R1: During and right after a synchronous active-low reset, both sample words are zero and `sample_valid` and `frame_err` are low.
- R2: With `fmt_sel` = 00, a low frame clock marks the left channel. The MSB is the bit sampled on the first rising edge after the one on which the frame-clock change is seen. Up to 24 bits follow, MSB first. Shorter words are left-aligned and their low bits are zero.
- R3: With `fmt_sel` = 10, a high frame clock marks the left channel. The MSB is the bit sampled on the same rising edge on which the frame-clock change is seen. Words shorter than 24 bits are left-aligned with zero low bits.
- R4: With `fmt_sel` = 01, a high frame clock marks the left channel. The word is the last 24 bits sampled before the frame-clock change, with the LSB last. Any earlier bits in that half have no effect.
- R5: With `fmt_sel` = 11, a high frame clock marks the left channel. The word is the last 16 bits before the change, and bit 15 is copied into bits 23:16.
- R6: In the MSB-aligned formats, bits that arrive after the 24th data bit of a half-frame have no effect on the word.
- R7: `sample_valid` is high for exactly one bit-clock cycle, starting one edge after the edge on which the frame clock is seen to leave the right-channel level. Both words change only in that cycle.
- R8: No strobe is produced until one whole left half and one whole right half have been received after reset. A half that was already running at reset is discarded.
- R9: `frame_err` is updated with each strobe and holds between strobes. It is 1 when the frame just finished, counted in bit clocks from one left-channel start to the next, was shorter than the minimum for the format: 50 for 00, 48 for 01, 32 for 10 and 48 for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing select: 00 I2S-style, 01 right-justified 24, 10 left-justified, 11 right-justified 16 |
| frame_clk | input | 1 | Channel-select frame clock |
| ser_data | input | 1 | Serial sample data, MSB first |
| left_sample | output | 24 | Left-channel word of the latest complete frame |
| right_sample | output | 24 | Right-channel word of the latest complete frame |
| sample_valid | output | 1 | One-cycle strobe when both words update |
| frame_err | output | 1 | Latest frame had too few bit clocks |

## Verification
A wrong bit position in the MSB-aligned accumulator, or a wrong tap on the shift register, shows up in the word delivered with the very next strobe: a whole-word mismatch or a missing sign extension. A wrong channel-level decode swaps the halves, so the left and right words come out exchanged in the first frame. A stuck or misaligned frame counter flips `frame_err` on frames that sit on either side of each format's minimum. A wrong arming state makes an extra strobe appear after reset, or makes the expected one go missing, within the first two frames.

// File: rtl/sarx_pkg.sv
// Shared types and format helpers for the serial audio receiver.
// Assumes the 2-bit select encoding fixed by the block's requirements.
package sarx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S      = 2'b00,
        FMT_RJ_FULL  = 2'b01,
        FMT_LJ       = 2'b10,
        FMT_RJ_SHORT = 2'b11
    } fmt_e;

    // Frame-clock level that marks the left channel.
    function automatic logic left_level(fmt_e f);
        return (f != FMT_I2S);
    endfunction

    // Bit clocks between the sampled frame-clock change and the MSB.
    function automatic logic msb_delay(fmt_e f);
        return (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/sarx_lr_edge.sv
// Frame-clock edge detector. Compares the frame clock sampled on this rising
// edge with the sample from the previous edge. Assumes the frame clock
// changes away from the rising bit-clock edge. The first sample after reset
// only primes the history and never reports an edge.
module sarx_lr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_in,
    output logic lr_edge,
    output logic lr_prev
);

    logic lr_q;
    logic primed;

    // Keep the previous frame-clock sample and note that the history is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q   <= 1'b0;
            primed <= 1'b0;
        end else begin
            lr_q   <= lr_in;
            primed <= 1'b1;
        end
    end

    assign lr_edge = primed && (lr_in != lr_q);
    assign lr_prev = lr_q;

endmodule

// File: rtl/sarx_shift_core.sv
// Shift engine shared by all four formats. An MSB-aligned accumulator places
// each bit by its slot after the frame-clock edge: slot 0 is the edge cycle,
// and the format delay moves the MSB to slot 0 or slot 1. An LSB-aligned
// shift register keeps the last DATA_W bits seen. word_done is the word that
// finishes on the current edge, formed from state before this cycle's update.
module sarx_shift_core
    import sarx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  fmt_e              fmt,
    input  logic              lr_edge,
    output logic [DATA_W-1:0] word_done
);

    localparam int SLOT_W = $clog2(DATA_W + 1) + 1;
    localparam logic [SLOT_W-1:0] SLOT_MAX = '1;
    localparam int EXT_W = DATA_W - SHORT_W;

    logic [DATA_W-1:0] msb_acc;
    logic [DATA_W-1:0] rj_shift;
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] offset;
    logic [SLOT_W-1:0] wr_idx;
    logic              delay;
    logic              in_range;

    assign delay    = msb_delay(fmt);
    assign offset   = slot - SLOT_W'(delay);
    assign in_range = (slot >= SLOT_W'(delay)) && (offset < SLOT_W'(DATA_W));
    assign wr_idx   = SLOT_W'(DATA_W - 1) - offset;

    // LSB-aligned capture: shift every bit in, the oldest falls out.
    always_ff @(posedge clk) begin
        if (!rst_n) rj_shift <= '0;
        else        rj_shift <= {rj_shift[DATA_W-2:0], sdata};
    end

    // Slot counter: restarts on each edge and saturates once past the word.
    always_ff @(posedge clk) begin
        if (!rst_n)              slot <= SLOT_MAX;
        else if (lr_edge)        slot <= SLOT_W'(1);
        else if (slot != SLOT_MAX) slot <= slot + SLOT_W'(1);
    end

    // MSB-aligned capture: clear on an edge, then write each bit at its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msb_acc <= '0;
        end else if (lr_edge) begin
            msb_acc <= delay ? '0 : {sdata, {(DATA_W-1){1'b0}}};
        end else begin
            for (int i = 0; i < DATA_W; i++) begin
                if (in_range && (wr_idx == SLOT_W'(i))) msb_acc[i] <= sdata;
            end
        end
    end

    // Pick the finished word for the active format.
    always_comb begin
        case (fmt)
            FMT_RJ_FULL:  word_done = rj_shift;
            FMT_RJ_SHORT: word_done = {{EXT_W{rj_shift[SHORT_W-1]}}, rj_shift[SHORT_W-1:0]};
            default:      word_done = msb_acc;
        endcase
    end

endmodule

// File: rtl/sarx_frame_ctl.sv
// Frame controller. Sorts edges into left-half ends and right-half ends, holds
// the left word until the right one is done, and publishes both with a
// one-cycle strobe. Only halves that begin on an observed edge are kept. It
// also counts bit clocks from one left start to the next and compares the
// count with the format's minimum.
module sarx_frame_ctl
    import sarx_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int CNT_W    = 8,
    parameter int MIN_I2S  = 50,
    parameter int MIN_RJF  = 48,
    parameter int MIN_LJ   = 32,
    parameter int MIN_RJS  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              lr_edge,
    input  logic              lr_prev,
    input  logic [DATA_W-1:0] word_done,
    output logic [DATA_W-1:0] left_word,
    output logic [DATA_W-1:0] right_word,
    output logic              valid,
    output logic              frame_err
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              left_end;
    logic              right_end;
    logic              armed;
    logic              left_ok;
    logic [DATA_W-1:0] left_hold;
    logic [CNT_W-1:0]  frame_cnt;
    logic [CNT_W-1:0]  min_len;

    assign left_end  = lr_edge && (lr_prev == left_level(fmt));
    assign right_end = lr_edge && (lr_prev != left_level(fmt));

    // Minimum frame length for the active format.
    always_comb begin
        case (fmt)
            FMT_I2S:     min_len = CNT_W'(MIN_I2S);
            FMT_RJ_FULL: min_len = CNT_W'(MIN_RJF);
            FMT_LJ:      min_len = CNT_W'(MIN_LJ);
            default:     min_len = CNT_W'(MIN_RJS);
        endcase
    end

    // Arming: a half counts only if an edge was seen before it started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            left_ok <= 1'b0;
        end else begin
            if (lr_edge)            armed   <= 1'b1;
            if (left_end && armed)  left_ok <= 1'b1;
        end
    end

    // Hold the finished left word until its right partner completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                left_hold <= '0;
        else if (left_end && armed) left_hold <= word_done;
    end

    // Frame length counter: restarts at each left start, saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)               frame_cnt <= CNT_MAX;
        else if (right_end)       frame_cnt <= CNT_W'(1);
        else if (frame_cnt != CNT_MAX) frame_cnt <= frame_cnt + CNT_W'(1);
    end

    // Publish both words, the strobe and the length verdict together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
            valid      <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (right_end && left_ok) begin
                left_word  <= left_hold;
                right_word <= word_done;
                valid      <= 1'b1;
                frame_err  <= (frame_cnt < min_len);
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
// Top of the multi-format serial audio receiver. Everything runs on the
// rising bit-clock edge. Assumes the frame clock and the data change away
// from that edge, and that the format select only changes under reset.
module audio_serial_rx
    import sarx_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16,
    parameter int CNT_W   = 8,
    parameter int MIN_I2S = 50,
    parameter int MIN_RJF = 48,
    parameter int MIN_LJ  = 32,
    parameter int MIN_RJS = 48
) (
    input  logic              bit_clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_sel,
    input  logic              frame_clk,
    input  logic              ser_data,
    output logic [DATA_W-1:0] left_sample,
    output logic [DATA_W-1:0] right_sample,
    output logic              sample_valid,
    output logic              frame_err
);

    fmt_e              fmt;
    logic              lr_edge;
    logic              lr_prev;
    logic [DATA_W-1:0] word_done;

    assign fmt = fmt_e'(fmt_sel);

    sarx_lr_edge u_edge (
        .clk     (bit_clk),
        .rst_n   (rst_n),
        .lr_in   (frame_clk),
        .lr_edge (lr_edge),
        .lr_prev (lr_prev)
    );

    sarx_shift_core #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_core (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .sdata     (ser_data),
        .fmt       (fmt),
        .lr_edge   (lr_edge),
        .word_done (word_done)
    );

    sarx_frame_ctl #(
        .DATA_W  (DATA_W),
        .CNT_W   (CNT_W),
        .MIN_I2S (MIN_I2S),
        .MIN_RJF (MIN_RJF),
        .MIN_LJ  (MIN_LJ),
        .MIN_RJS (MIN_RJS)
    ) u_ctl (
        .clk        (bit_clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .lr_edge    (lr_edge),
        .lr_prev    (lr_prev),
        .word_done  (word_done),
        .left_word  (left_sample),
        .right_word (right_sample),
        .valid      (sample_valid),
        .frame_err  (frame_err)
    );

endmodule

// File: rtl/audio_serial_rx_chk.sv
// Port-level property checker for the serial audio receiver, bound to the top.
module audio_serial_rx_chk #(
    parameter int DATA_W  = 24,
    parameter int SHORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        fmt_sel,
    input logic [DATA_W-1:0] left_sample,
    input logic [DATA_W-1:0] right_sample,
    input logic              sample_valid,
    input logic              frame_err
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);  // R7

    AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(left_sample) && $stable(right_sample)));  // R7

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(frame_err));  // R9

    AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !sample_valid);  // R8

    AST_SHORT_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && $past(fmt_sel) == 2'b11) |->
        ((right_sample[DATA_W-1:SHORT_W] == {(DATA_W-SHORT_W){right_sample[SHORT_W-1]}}) &&
         (left_sample[DATA_W-1:SHORT_W]  == {(DATA_W-SHORT_W){left_sample[SHORT_W-1]}})));  // R5

endmodule

bind audio_serial_rx audio_serial_rx_chk #(
    .DATA_W  (DATA_W),
    .SHORT_W (SHORT_W)
) u_chk (
    .clk          (bit_clk),
    .rst_n        (rst_n),
    .fmt_sel      (fmt_sel),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .sample_valid (sample_valid),
    .frame_err    (frame_err)
);

// File: tb/audio_serial_rx_bench.sv
// Scoreboard bench: the driver pushes expected frames, the monitor pops them
// on each strobe and compares.
module audio_serial_rx_bench;

    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        frame_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [23:0] left_sample;
    logic [23:0] right_sample;
    logic        sample_valid;
    logic        frame_err;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        logic        e;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #5 bit_clk = ~bit_clk;

    audio_serial_rx u_audio_serial_rx (
        .bit_clk      (bit_clk),
        .rst_n        (rst_n),
        .fmt_sel      (fmt_sel),
        .frame_clk    (frame_clk),
        .ser_data     (ser_data),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .sample_valid (sample_valid),
        .frame_err    (frame_err)
    );

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic bit left_lvl(int f);
        return (f != 0);
    endfunction

    function automatic int min_len(int f);
        case (f)
            0: return 50;
            1: return 48;
            2: return 32;
            default: return 48;
        endcase
    endfunction

    function automatic string word_req(logic [1:0] f);
        case (f)
            2'b00: return "R2";
            2'b01: return "R4";
            2'b10: return "R3";
            default: return "R5";
        endcase
    endfunction

    // Bit to send in slot s of a half of H slots; padding is 1 (must be ignored).
    function automatic bit slot_bit(int f, int h, int s, logic [31:0] data, int nb);
        int idx;
        case (f)
            0: idx = s - 1;
            2: idx = s;
            default: idx = s - (h - nb);
        endcase
        if (idx >= 0 && idx < nb) return data[nb-1-idx];
        return 1'b1;
    endfunction

    function automatic logic [23:0] exp_word(int f, logic [31:0] data, int nb);
        logic [31:0] m;
        m = data & ((32'd1 << nb) - 32'd1);
        case (f)
            1: return data[23:0];
            3: return {{8{data[15]}}, data[15:0]};
            default: return 24'(m << (24 - nb));
        endcase
    endfunction

    task automatic drive_slot(bit fc, bit d);
        @(negedge bit_clk);
        frame_clk = fc;
        ser_data  = d;
    endtask

    task automatic send_half(bit lvl, int f, int h, logic [31:0] data, int nb);
        for (int s = 0; s < h; s++) drive_slot(lvl, slot_bit(f, h, s, data, nb));
    endtask

    task automatic send_frame(int f, int h, logic [31:0] l, logic [31:0] r, int nb, bit push);
        exp_t x;
        send_half(left_lvl(f), f, h, l, nb);
        send_half(!left_lvl(f), f, h, r, nb);
        if (push) begin
            x.l = exp_word(f, l, nb);
            x.r = exp_word(f, r, nb);
            x.e = (2 * h < min_len(f));
            exp_q.push_back(x);
        end
    endtask

    task automatic do_reset(int f, bit lvl);
        @(negedge bit_clk);
        rst_n     = 1'b0;
        fmt_sel   = 2'(f);
        frame_clk = lvl;
        ser_data  = 1'b0;
        repeat (3) @(negedge bit_clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_group();
        repeat (4) drive_slot(frame_clk, 1'b0);
        check(exp_q.size() == 0, "R7", "strobes missing at end of group", 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    // Monitor: compare each strobe with the scoreboard and watch strobe width.
    bit prev_valid = 1'b0;
    always @(negedge bit_clk) begin
        if (rst_n && sample_valid) begin
            if (prev_valid) begin
                fails++;
                $display("FAIL R7 strobe longer than one cycle: actual 1 expected 0");
            end
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 unexpected strobe: actual 1 expected 0");
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(left_sample == x.l, word_req(fmt_sel), "left word", 32'(left_sample), 32'(x.l));
                check(right_sample == x.r, word_req(fmt_sel), "right word", 32'(right_sample), 32'(x.r));
                check(frame_err == x.e, "R9", "frame error flag", 32'(frame_err), 32'(x.e));
            end
        end
        prev_valid = rst_n && sample_valid;
    end

    initial begin
        // I2S-style: right level is high; R1 reset state checked first.
        do_reset(0, 1'b1);
        @(negedge bit_clk);
        check(left_sample == 0 && right_sample == 0, "R1", "words after reset",
              32'(left_sample ^ right_sample), 32'd0);
        check(!sample_valid && !frame_err, "R1", "strobe/err after reset",
              {30'd0, sample_valid, frame_err}, 32'd0);
        send_frame(0, 32, 32'hA5C3E1, 32'h123456, 24, 1);  // R6 padding after 24 bits
        send_frame(0, 32, 32'h800001, 32'h7FFFFE, 24, 1);
        send_frame(0, 25, 32'h5A5A5A, 32'hC0FFEE, 24, 1);  // 50 clocks: R9 no error
        send_frame(0, 24, 32'h2AAAAA, 32'h555555, 23, 1);  // 48 clocks: R9 error, R2 short word
        send_frame(0, 32, 32'h0, 32'h0, 24, 0);
        finish_group();

        // Left-justified, R3.
        do_reset(2, 1'b0);
        send_frame(2, 32, 32'h13579B, 32'hFDB975, 24, 1);
        send_frame(2, 16, 32'hBEEF, 32'h1234, 16, 1);      // 32 clocks: no error
        send_frame(2, 15, 32'h4321, 32'h7ACE, 15, 1);      // 30 clocks: R9 error
        send_frame(2, 32, 32'h00FF00, 32'hFF00FF, 24, 1);  // R9 cleared again
        send_frame(2, 32, 32'h0, 32'h0, 24, 0);
        finish_group();

        // Right-justified 24, R4.
        do_reset(1, 1'b0);
        send_frame(1, 32, 32'hABCDEF, 32'h010203, 24, 1);
        send_frame(1, 32, 32'h800000, 32'h7FFFFF, 24, 1);
        send_frame(1, 24, 32'h600DF0, 32'h0FF1CE, 24, 1);
        send_frame(1, 32, 32'h0, 32'h0, 24, 0);
        finish_group();

        // Right-justified 16 with sign extension, R5.
        do_reset(3, 1'b0);
        send_frame(3, 32, 32'h8001, 32'h7ABC, 16, 1);
        send_frame(3, 24, 32'hFFFF, 32'h0001, 16, 1);
        send_frame(3, 20, 32'h9876, 32'h1357, 16, 1);      // 40 clocks: R9 error
        send_frame(3, 32, 32'h0, 32'h0, 16, 0);
        finish_group();

        // R8: reset inside a left half; that half and its right partner are dropped.
        do_reset(2, 1'b1);
        repeat (5) drive_slot(1'b1, 1'b1);
        send_half(1'b0, 2, 32, 32'hDEAD00, 24);
        send_frame(2, 32, 32'h246800, 32'h135700, 24, 1);
        send_frame(2, 32, 32'h0, 32'h0, 24, 0);
        finish_group();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bit_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule